// File: doc/BRIEF.md
# Registered-Macrocell AND/OR Logic Array

This block is a small field-configurable logic device. Each output owns a macrocell that ORs a fixed group of product terms. Every product term is built by a programmable AND plane from the dedicated inputs and from a feedback bus. The macrocell can either pass that OR result straight through, or register it on the rising clock edge. A per-output enable decides whether the pin is driven or left floating.

The macrocell's selected value, not the pin, is sent back into the AND plane in both true and inverted form. This lets one array hold multi-level logic and small state machines. The full configuration vector is captured while reset is high and stays fixed until the next reset. The same reset clears every flip-flop.

Top module: `pal_array`

## Requirements
- R1: The configuration register copies `cfg_i` on every clock edge at which `rst` is high, and ignores `cfg_i` at every other time.
- R2: Every literal of a product term has a 2-bit code. Bit 0 set includes the literal in true form and bit 1 set includes it in inverted form. The term is the AND of its included literals. Literals are numbered with the dedicated inputs first, then the feedback bits. Macrocell m's field begins at m*MC_W. Term t, literal l sits at offset (t*N_LIT+l)*2. Bit N_PT*N_LIT*2 is the register select and the next bit is the output enable.
- R3: A product term in which any literal has both code bits set is 0 for every input.
- R4: A product term with no code bit set is 0, so an unused term never asserts its OR output.
- R5: Each macrocell output is the OR of its own N_PT product terms.
- R6: In registered mode (select bit 1), the macrocell value changes only on a rising clock edge, where it takes the OR result present before that edge.
- R7: In combinational mode (select bit 0), the macrocell value follows the OR result with no clock.
- R8: With the enable bit 1 the pin drives the macrocell value. With it 0 the pin is high-impedance.
- R9: Feedback carries the macrocell value even while its pin is high-impedance.
- R10: Every flip-flop reads 0 after a clock edge with `rst` high.
- R11: With set/reset next-state equations, a registered macrocell plus feedback forms a two-state machine whose state and decoded output follow an input sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flip-flops capture on its rising edge |
| rst | input | 1 | Synchronous active-high reset; loads configuration and clears flip-flops |
| cfg_i | input | N_MC*MC_W | Configuration vector, sampled only during reset |
| in_i | input | N_IN | Dedicated logic inputs |
| pin_o | output | N_MC | Tri-stated macrocell output pins |

## Verification
The bench builds the array with two dedicated inputs, two macrocells and three terms per macrocell. With these sizes every term code and every mode bit can be set by hand, and the whole input space of a combinational function fits in four vectors. Two macrocells are enough to register a state in one and decode it in the other through feedback. The same pair can show a floating, pulled-up pin while the neighbour still sees its value.

// File: rtl/pal_pkg.sv
package pal_pkg;

  // Two-bit literal code stored per literal per product term.
  typedef enum logic [1:0] {
    LIT_OFF  = 2'b00,
    LIT_POS  = 2'b01,
    LIT_NEG  = 2'b10,
    LIT_VOID = 2'b11
  } lit_code_e;

  localparam int unsigned CODE_W   = 2;
  localparam int unsigned POS_BIT  = 0;
  localparam int unsigned NEG_BIT  = 1;
  localparam int unsigned MODE_W   = 2;

endpackage

// File: rtl/pal_term.sv
module pal_term
  import pal_pkg::*;
#(
  parameter int unsigned N_LIT = 8
) (
  input  logic [N_LIT-1:0]        lit_i,
  input  logic [N_LIT*CODE_W-1:0] sel_i,
  output logic                    term_o
);

  always_comb begin
    logic acc;
    acc = |sel_i;
    for (int l = 0; l < N_LIT; l++) begin
      if (sel_i[l*CODE_W+POS_BIT] && !lit_i[l]) acc = 1'b0;
      if (sel_i[l*CODE_W+NEG_BIT] &&  lit_i[l]) acc = 1'b0;
    end
    term_o = acc;
  end

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_pkg::*;
#(
  parameter int unsigned N_LIT = 8,
  parameter int unsigned N_PT  = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_LIT-1:0]             lit_i,
  input  logic [N_PT*N_LIT*CODE_W-1:0] sel_i,
  input  logic                         reg_sel_i,
  input  logic                         oe_i,
  output logic                         fb_o,
  output logic                         pin_o
);

  localparam int unsigned TERM_W = N_LIT*CODE_W;

  logic [N_PT-1:0] terms;
  logic            sum;
  logic            q;

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    pal_term #(.N_LIT(N_LIT)) u_term (
      .lit_i  (lit_i),
      .sel_i  (sel_i[t*TERM_W +: TERM_W]),
      .term_o (terms[t])
    );

    function automatic logic has_void(input logic [TERM_W-1:0] s);
      logic v;
      v = 1'b0;
      for (int l = 0; l < N_LIT; l++)
        if (s[l*CODE_W+POS_BIT] && s[l*CODE_W+NEG_BIT]) v = 1'b1;
      return v;
    endfunction

    // R3: a literal coded both ways kills the whole term
    a_r3_void_literal: assert property (@(posedge clk) disable iff (rst)
      has_void(sel_i[t*TERM_W +: TERM_W]) |-> !terms[t]);

    // R4: an empty term never asserts
    a_r4_blank_term: assert property (@(posedge clk) disable iff (rst)
      (sel_i[t*TERM_W +: TERM_W] == '0) |-> !terms[t]);
  end

  assign sum = |terms;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= sum;
  end

  assign fb_o  = reg_sel_i ? q : sum;
  assign pin_o = oe_i ? fb_o : 1'bz;

  // R6: registered value is the OR result sampled one edge earlier
  a_r6_capture: assert property (@(posedge clk) disable iff (rst)
    (reg_sel_i && !$past(rst)) |-> fb_o == $past(sum));

  // R10: reset clears the flip-flop
  a_r10_clear: assert property (@(posedge clk)
    rst |=> (q == 1'b0));

endmodule

// File: rtl/pal_array.sv
module pal_array
  import pal_pkg::*;
#(
  parameter int unsigned N_IN = 4,
  parameter int unsigned N_MC = 4,
  parameter int unsigned N_PT = 4,
  localparam int unsigned N_LIT = N_IN + N_MC,
  localparam int unsigned SEL_W = N_PT*N_LIT*CODE_W,
  localparam int unsigned MC_W  = SEL_W + MODE_W,
  localparam int unsigned CFG_W = N_MC*MC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [N_IN-1:0]  in_i,
  output logic [N_MC-1:0]  pin_o
);

  logic [CFG_W-1:0] cfg_q;
  logic [N_MC-1:0]  fb;
  logic [N_LIT-1:0] lits;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= cfg_i;
  end

  assign lits = {fb, in_i};

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    pal_macrocell #(.N_LIT(N_LIT), .N_PT(N_PT)) u_mc (
      .clk       (clk),
      .rst       (rst),
      .lit_i     (lits),
      .sel_i     (cfg_q[m*MC_W +: SEL_W]),
      .reg_sel_i (cfg_q[m*MC_W + SEL_W]),
      .oe_i      (cfg_q[m*MC_W + SEL_W + 1]),
      .fb_o      (fb[m]),
      .pin_o     (pin_o[m])
    );
  end

  // R1: configuration frozen outside reset
  a_r1_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(cfg_q));

endmodule

// File: tb/test_pal_array.sv
`timescale 1ns/1ps
module test_pal_array;
  import pal_pkg::*;

  localparam int NI = 2, NM = 2, NP = 3;
  localparam int NL = NI + NM;
  localparam int SW = NP*NL*2;
  localparam int MW = SW + 2;
  localparam int CW = NM*MW;
  // literal numbers
  localparam int LP = 0, LQ = 1, LF0 = 2, LF1 = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] cfg_i = '0;
  logic [NI-1:0] in_i = '0;
  wire  [NM-1:0] pin_w;
  pullup (pin_w[0]);
  pullup (pin_w[1]);

  int total = 0;
  int bad   = 0;
  logic [CW-1:0] cfg;

  always #4 clk = ~clk;

  pal_array #(.N_IN(NI), .N_MC(NM), .N_PT(NP)) i_pal_array (
    .clk(clk), .rst(rst), .cfg_i(cfg_i), .in_i(in_i), .pin_o(pin_w)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic put_lit(input int m, input int t, input int l, input lit_code_e c);
    cfg[m*MW + (t*NL + l)*2 +: 2] = c;
  endtask

  task automatic put_mode(input int m, input logic regd, input logic oe);
    cfg[m*MW + SW]     = regd;
    cfg[m*MW + SW + 1] = oe;
  endtask

  task automatic load_cfg();
    @(negedge clk);
    cfg_i = cfg;
    rst   = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // {P, Q, exp pin0, exp pin1}
  localparam logic [3:0] COMB_VEC [4] = '{
    4'b00_0_1, 4'b01_0_0, 4'b10_1_0, 4'b11_0_1
  };
  // {P, Q, exp state, exp decode}
  localparam logic [3:0] FSM_VEC [8] = '{
    4'b00_0_0, 4'b10_1_1, 4'b00_1_0, 4'b11_0_0,
    4'b01_0_0, 4'b10_1_1, 4'b10_1_1, 4'b01_0_0
  };

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // Config A: combinational logic, R2 R3 R4 R5 R7 R8
    cfg = '0;
    put_mode(0, 1'b0, 1'b1);
    put_lit(0, 0, LP, LIT_POS); put_lit(0, 0, LQ, LIT_NEG);
    put_lit(0, 1, LP, LIT_VOID);                 // dead term
    put_mode(1, 1'b0, 1'b1);
    put_lit(1, 0, LP, LIT_POS); put_lit(1, 0, LQ, LIT_POS);
    put_lit(1, 1, LP, LIT_NEG); put_lit(1, 1, LQ, LIT_NEG);
    load_cfg();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_i = {COMB_VEC[i][2], COMB_VEC[i][3]};
      #1;
      check("R2_R3_R4 and-term pin0", pin_w[0], COMB_VEC[i][1]);
      check("R5_R7_R8 or-group pin1", pin_w[1], COMB_VEC[i][0]);
    end

    // Config B: set/reset state machine, R6 R10 R11
    cfg = '0;
    put_mode(0, 1'b1, 1'b1);
    put_lit(0, 0, LP, LIT_POS);  put_lit(0, 0, LQ, LIT_NEG);
    put_lit(0, 1, LF0, LIT_POS); put_lit(0, 1, LQ, LIT_NEG);
    put_mode(1, 1'b0, 1'b1);
    put_lit(1, 0, LF0, LIT_POS); put_lit(1, 0, LP, LIT_POS);
    in_i = '0;
    load_cfg();
    check("R10 state after reset", pin_w[0], 1'b0);
    check("R10 decode after reset", pin_w[1], 1'b0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_i = {FSM_VEC[i][2], FSM_VEC[i][3]};
      @(posedge clk);
      @(negedge clk);
      check("R11 state", pin_w[0], FSM_VEC[i][1]);
      check("R11 decode", pin_w[1], FSM_VEC[i][0]);
    end
    in_i = 2'b01;                                // P=1 Q=0 : set
    #1;
    check("R6 hold before edge", pin_w[0], 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R6 capture on edge", pin_w[0], 1'b1);
    load_cfg();
    check("R10 clear from state 1", pin_w[0], 1'b0);

    // Config C: hidden toggle, R1 R8 R9
    cfg = '0;
    put_mode(0, 1'b1, 1'b0);
    put_lit(0, 0, LF0, LIT_NEG);
    put_mode(1, 1'b0, 1'b1);
    put_lit(1, 0, LF0, LIT_POS);
    in_i = '0;
    load_cfg();
    check("R8 floating pin pulled", pin_w[0], 1'b1);
    check("R9 feedback start", pin_w[1], 1'b0);
    cfg_i = '0;                                  // must be ignored
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R9_R1 feedback toggles", pin_w[1], (i % 2 == 0));
      check("R8 pin stays floating", pin_w[0], 1'b1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule